// File: doc/BRIEF.md
# I2C Register-Access Target

This block sits on a two-wire I2C bus as a target device and lets a bus controller read and write a 64-entry file of 8-bit registers. It runs on a fast system clock and oversamples SCL and SDA through synchronizer flops. It detects start, repeated-start and stop conditions and matches its 7-bit device address. It acknowledges accepted bytes and then moves data between the bus and an external register file. The register file is reached through a pointer-addressed port: one write strobe with address and data, and one combinational read-data input.

A write is an address byte with the write bit clear, then a register-pointer byte, then any number of data bytes. A read first loads the pointer in a write, then re-addresses the device with the read bit set, after either a repeated start or a stop and a new start. The pointer advances after every data byte, in both directions. A strap pin chooses which of two fixed device addresses the block answers to. The block never drives SDA high. Its only output toward the pad is a pull-low enable.

Top module: `i2c_reg_target`

## Requirements
- R1: With `addr_sel_i` high the block acknowledges address byte 0x3A (write) and 0x3B (read), that is device address 0x1D. With `addr_sel_i` low it acknowledges 0xA6 and 0xA7 (device address 0x53). It does not acknowledge the other strap's address.
- R2: After an address byte that does not match, the block keeps SDA released and performs no register write until the next start condition.
- R3: In a write, the byte after the address sets the register pointer from its low 6 bits. Each following data byte is acknowledged and produces exactly one single-cycle `reg_we_o` pulse, carrying the byte on `reg_wdata_o` and the pointer on `reg_addr_o`.
- R4: The pointer increments by one after every data byte, written or read, and wraps from 63 to 0.
- R5: In a read, the block shifts out the register at the pointer, MSB first. The pointer value is kept across a repeated start and across a stop followed by a start.
- R6: In a burst read, a controller ACK (SDA low on the ninth clock) makes the block send the next register. A NACK makes it release SDA and send nothing more until a start or stop.
- R7: A start seen mid-byte restarts address reception. A stop seen mid-byte returns the block to idle with SDA released and no register write.
- R8: The pull-low enable only turns on while the synchronized SCL is low.
- R9: Operation does not depend on bus rate, as long as each SCL high and low phase lasts at least 4 system clocks. This covers both 100 kHz and 400 kHz buses with a system clock of 16 MHz or more.
- R10: After reset SDA is released and no register write is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL pad input (asynchronous) |
| sda_i | input | 1 | SDA pad input (asynchronous) |
| addr_sel_i | input | 1 | Address strap: 1 selects 0x1D, 0 selects 0x53 |
| sda_oe_o | output | 1 | Pull SDA low when 1, release when 0 |
| reg_we_o | output | 1 | Single-cycle register write strobe |
| reg_addr_o | output | 6 | Register pointer, used for both write and read |
| reg_wdata_o | output | 8 | Write data, valid with `reg_we_o` |
| reg_rdata_i | input | 8 | Read data for the register at `reg_addr_o` |

## Verification
A wrong internal state shows up at the pads within one bus clock. A mis-sequenced bit counter or state sets the ACK or data bit on the wrong SCL pulse, so the controller model sees a missing or false acknowledge at the next ninth clock. A wrong pointer appears as a write to the wrong register, or as a wrong byte read back in the same burst. A block that fails to go quiet after a mismatch or a NACK pulls SDA low on the very next byte. The bench checks that byte directly.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_TX,
        ST_MACK,
        ST_SKIP
    } tgt_state_e;

endpackage

// File: rtl/i2c_rp_sync.sv
module i2c_rp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d          = sync_q;
        sync_d.scl_sh   = {sync_q.scl_sh[STAGES-2:0], scl_i};
        sync_d.sda_sh   = {sync_q.sda_sh[STAGES-2:0], sda_i};
        sync_d.scl_prev = sync_q.scl_sh[STAGES-1];
        sync_d.sda_prev = sync_q.sda_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign scl_s     = sync_q.scl_sh[STAGES-1];
    assign sda_s     = sync_q.sda_sh[STAGES-1];
    assign scl_rise  = scl_s & ~sync_q.scl_prev;
    assign scl_fall  = ~scl_s & sync_q.scl_prev;
    assign start_det = scl_s & sync_q.scl_prev & sync_q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & sync_q.scl_prev & ~sync_q.sda_prev & sda_s;

endmodule

// File: rtl/i2c_rp_addr_match.sv
module i2c_rp_addr_match #(
    parameter logic [6:0] DEV_ADDR_HI = 7'h1D,
    parameter logic [6:0] DEV_ADDR_LO = 7'h53
) (
    input  logic       addr_sel_i,
    input  logic [6:0] addr_field_i,
    output logic       hit_o
);

    logic [6:0] own_addr;

    always_comb begin
        own_addr = addr_sel_i ? DEV_ADDR_HI : DEV_ADDR_LO;
        hit_o    = (addr_field_i == own_addr);
    end

endmodule

// File: rtl/i2c_rp_ctrl.sv
module i2c_rp_ctrl
    import i2c_rp_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              addr_hit,
    output logic [6:0]        addr_field_o,
    input  logic [BYTE_W-1:0] reg_rdata_i,
    output logic              sda_oe_o,
    output logic              reg_we_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [BYTE_W-1:0] reg_wdata_o
);

    localparam logic [CNT_W-1:0] BITS_PER_BYTE = CNT_W'(BYTE_W);

    typedef struct packed {
        tgt_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic [ADDR_W-1:0] ptr;
        logic              oe;
        logic              rw;
        logic              nack;
        logic              we;
        logic [BYTE_W-1:0] wdata;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d    = ctrl_q;
        ctrl_d.we = 1'b0;
        if (ctrl_q.we) begin
            ctrl_d.ptr = ctrl_q.ptr + 1'b1;
        end
        if (stop_det) begin
            ctrl_d.st  = ST_IDLE;
            ctrl_d.oe  = 1'b0;
            ctrl_d.cnt = '0;
        end else if (start_det) begin
            ctrl_d.st  = ST_ADDR;
            ctrl_d.oe  = 1'b0;
            ctrl_d.cnt = '0;
        end else begin
            case (ctrl_q.st)
                ST_ADDR, ST_PTR, ST_WR: begin
                    if (scl_rise && ctrl_q.cnt < BITS_PER_BYTE) begin
                        ctrl_d.sh  = {ctrl_q.sh[BYTE_W-2:0], sda_s};
                        ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                    end else if (scl_fall && ctrl_q.cnt == BITS_PER_BYTE) begin
                        ctrl_d.cnt = '0;
                        case (ctrl_q.st)
                            ST_ADDR: begin
                                if (addr_hit) begin
                                    ctrl_d.oe = 1'b1;
                                    ctrl_d.rw = ctrl_q.sh[0];
                                    ctrl_d.st = ST_ADDR_ACK;
                                end else begin
                                    ctrl_d.st = ST_SKIP;
                                end
                            end
                            ST_PTR: begin
                                ctrl_d.ptr = ctrl_q.sh[ADDR_W-1:0];
                                ctrl_d.oe  = 1'b1;
                                ctrl_d.st  = ST_PTR_ACK;
                            end
                            default: begin
                                ctrl_d.we    = 1'b1;
                                ctrl_d.wdata = ctrl_q.sh;
                                ctrl_d.oe    = 1'b1;
                                ctrl_d.st    = ST_WR_ACK;
                            end
                        endcase
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (ctrl_q.rw) begin
                            ctrl_d.sh  = {reg_rdata_i[BYTE_W-2:0], 1'b0};
                            ctrl_d.oe  = ~reg_rdata_i[BYTE_W-1];
                            ctrl_d.cnt = CNT_W'(1);
                            ctrl_d.st  = ST_TX;
                        end else begin
                            ctrl_d.oe = 1'b0;
                            ctrl_d.st = ST_PTR;
                        end
                    end
                end
                ST_PTR_ACK, ST_WR_ACK: begin
                    if (scl_fall) begin
                        ctrl_d.oe = 1'b0;
                        ctrl_d.st = ST_WR;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (ctrl_q.cnt == BITS_PER_BYTE) begin
                            ctrl_d.oe  = 1'b0;
                            ctrl_d.cnt = '0;
                            ctrl_d.st  = ST_MACK;
                        end else begin
                            ctrl_d.oe  = ~ctrl_q.sh[BYTE_W-1];
                            ctrl_d.sh  = {ctrl_q.sh[BYTE_W-2:0], 1'b0};
                            ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        ctrl_d.ptr  = ctrl_q.ptr + 1'b1;
                        ctrl_d.nack = sda_s;
                    end else if (scl_fall) begin
                        if (!ctrl_q.nack) begin
                            ctrl_d.sh  = {reg_rdata_i[BYTE_W-2:0], 1'b0};
                            ctrl_d.oe  = ~reg_rdata_i[BYTE_W-1];
                            ctrl_d.cnt = CNT_W'(1);
                            ctrl_d.st  = ST_TX;
                        end else begin
                            ctrl_d.st = ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            ctrl_q.st <= ST_IDLE;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign addr_field_o = ctrl_q.sh[BYTE_W-1:1];
    assign sda_oe_o     = ctrl_q.oe;
    assign reg_we_o     = ctrl_q.we;
    assign reg_addr_o   = ctrl_q.ptr;
    assign reg_wdata_o  = ctrl_q.wdata;

    // R8: pull-low only begins while SCL is low
    p_drive_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q.oe) |-> !scl_s);

    // R7: a stop always leaves the line released and no write pending
    p_stop_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!ctrl_q.oe && ctrl_q.st == ST_IDLE && !ctrl_q.we));

    // R7: a start restarts address reception
    p_start_to_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (ctrl_q.st == ST_ADDR && ctrl_q.cnt == '0));

    // R2: an unmatched transaction stays silent
    p_skip_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.st == ST_SKIP) |-> (!ctrl_q.oe && !ctrl_q.we));

    // R3: write strobe lasts one cycle
    p_we_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.we |=> !ctrl_q.we);

    // R4: pointer advances after each written byte
    p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.we |=> (ctrl_q.ptr == $past(ctrl_q.ptr) + 1'b1));

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
    parameter int         ADDR_W      = 6,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR_HI = 7'h1D,
    parameter logic [6:0] DEV_ADDR_LO = 7'h53
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_sel_i,
    output logic              sda_oe_o,
    output logic              reg_we_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [7:0]        reg_wdata_o,
    input  logic [7:0]        reg_rdata_i
);

    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       addr_hit;
    logic [6:0] addr_field;

    i2c_rp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_rp_addr_match #(
        .DEV_ADDR_HI (DEV_ADDR_HI),
        .DEV_ADDR_LO (DEV_ADDR_LO)
    ) u_match (
        .addr_sel_i   (addr_sel_i),
        .addr_field_i (addr_field),
        .hit_o        (addr_hit)
    );

    i2c_rp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_s        (scl_s),
        .sda_s        (sda_s),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .addr_hit     (addr_hit),
        .addr_field_o (addr_field),
        .reg_rdata_i  (reg_rdata_i),
        .sda_oe_o     (sda_oe_o),
        .reg_we_o     (reg_we_o),
        .reg_addr_o   (reg_addr_o),
        .reg_wdata_o  (reg_wdata_o)
    );

    // R10: quiet out of reset
    p_reset_quiet_r10: assert property (@(posedge clk)
        $rose(rst_n) |-> (!sda_oe_o && !reg_we_o));

endmodule

// File: tb/i2c_reg_target_tb.sv
module i2c_reg_target_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda_low = 1'b0;
    logic       addr_sel = 1'b1;
    logic       sda_oe;
    logic       reg_we;
    logic [5:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       sda_line;

    logic [7:0] mem [64];
    int         wr_count = 0;
    int         q = 8;
    int         n_chk = 0;
    int         n_fail = 0;

    always #2 clk = ~clk;

    assign sda_line  = ~(m_sda_low | sda_oe);
    assign reg_rdata = mem[reg_addr];

    i2c_reg_target u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (m_scl),
        .sda_i       (sda_line),
        .addr_sel_i  (addr_sel),
        .sda_oe_o    (sda_oe),
        .reg_we_o    (reg_we),
        .reg_addr_o  (reg_addr),
        .reg_wdata_o (reg_wdata),
        .reg_rdata_i (reg_rdata)
    );

    always @(posedge clk) begin
        if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            wr_count      <= wr_count + 1;
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; wclk(q);
        m_scl = 1'b1;     wclk(q);
        m_sda_low = 1'b1; wclk(q);
        m_scl = 1'b0;     wclk(q);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; wclk(q);
        m_scl = 1'b1;     wclk(q);
        m_sda_low = 1'b0; wclk(2 * q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            wclk(q);
            m_sda_low = ~b[i];
            wclk(q);
            m_scl = 1'b1;
            wclk(2 * q);
            m_scl = 1'b0;
        end
    endtask

    task automatic wbyte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        wclk(q);
        m_sda_low = 1'b0;
        wclk(q);
        m_scl = 1'b1;
        wclk(q);
        acked = ~sda_line;
        wclk(q);
        m_scl = 1'b0;
    endtask

    task automatic rbyte(input bit give_ack, output logic [7:0] d);
        m_sda_low = 1'b0;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            wclk(2 * q);
            m_scl = 1'b1;
            wclk(q);
            d = {d[6:0], sda_line};
            wclk(q);
            m_scl = 1'b0;
        end
        wclk(q);
        m_sda_low = give_ack;
        wclk(q);
        m_scl = 1'b1;
        wclk(2 * q);
        m_scl = 1'b0;
        wclk(q);
        m_sda_low = 1'b0;
    endtask

    task automatic t_reset();
        chk(sda_oe == 1'b0, "R10 sda released", sda_oe, 0);
        chk(reg_we == 1'b0 && wr_count == 0, "R10 no write", wr_count, 0);
    endtask

    task automatic t_write_hi();
        bit a;
        addr_sel = 1'b1;
        bus_start();
        wbyte(8'h3A, a); chk(a, "R1 ack 0x3A", a, 1);
        wbyte(8'h05, a); chk(a, "R3 ack pointer", a, 1);
        wbyte(8'h11, a); chk(a, "R3 ack data", a, 1);
        wbyte(8'h22, a);
        wbyte(8'h33, a);
        bus_stop();
        chk(mem[5] == 8'h11, "R3 reg5", mem[5], 8'h11);
        chk(mem[6] == 8'h22 && mem[7] == 8'h33, "R4 increment", {mem[6], mem[7]}, 16'h2233);
        chk(wr_count == 3, "R3 one strobe per byte", wr_count, 3);
    endtask

    task automatic t_read_burst();
        bit a;
        logic [7:0] d;
        bus_start();
        wbyte(8'h3A, a);
        wbyte(8'h05, a);
        bus_start();
        wbyte(8'h3B, a); chk(a, "R1 ack 0x3B", a, 1);
        rbyte(1'b1, d); chk(d == 8'h11, "R5 read first", d, 8'h11);
        rbyte(1'b1, d); chk(d == 8'h22, "R6 read after ACK", d, 8'h22);
        rbyte(1'b0, d); chk(d == 8'h33, "R6 read last", d, 8'h33);
        wclk(2 * q);
        chk(sda_oe == 1'b0, "R6 released after NACK", sda_oe, 0);
        bus_stop();
    endtask

    task automatic t_mismatch();
        bit a;
        int wc;
        wc = wr_count;
        addr_sel = 1'b1;
        bus_start();
        wbyte(8'hA6, a); chk(!a, "R2 no ack other address", a, 0);
        wbyte(8'h00, a); chk(!a, "R2 silent byte", a, 0);
        wbyte(8'h77, a); chk(!a, "R2 silent byte 2", a, 0);
        bus_stop();
        chk(wr_count == wc, "R2 no write", wr_count, wc);
    endtask

    task automatic t_strap_lo_wrap();
        bit a;
        addr_sel = 1'b0;
        bus_start();
        wbyte(8'hA6, a); chk(a, "R1 ack 0xA6", a, 1);
        wbyte(8'hFE, a);
        wbyte(8'hAA, a);
        wbyte(8'hBB, a);
        wbyte(8'hCC, a);
        bus_stop();
        chk(mem[62] == 8'hAA && mem[63] == 8'hBB, "R3 pointer low bits", {mem[62], mem[63]}, 16'hAABB);
        chk(mem[0] == 8'hCC, "R4 wrap to 0", mem[0], 8'hCC);
        bus_start();
        wbyte(8'h3A, a); chk(!a, "R1 0x3A refused when strap low", a, 0);
        bus_stop();
    endtask

    task automatic t_stop_start_read();
        bit a;
        logic [7:0] d;
        addr_sel = 1'b0;
        bus_start();
        wbyte(8'hA6, a); wbyte(8'h10, a); wbyte(8'h5A, a); wbyte(8'h6B, a);
        bus_stop();
        bus_start();
        wbyte(8'hA6, a); wbyte(8'h10, a);
        bus_stop();
        bus_start();
        wbyte(8'hA7, a); chk(a, "R1 ack 0xA7", a, 1);
        rbyte(1'b1, d); chk(d == 8'h5A, "R5 pointer kept over stop", d, 8'h5A);
        rbyte(1'b0, d); chk(d == 8'h6B, "R4 read increment", d, 8'h6B);
        bus_stop();
    endtask

    task automatic t_abort();
        bit a;
        int wc;
        addr_sel = 1'b0;
        bus_start();
        send_bits(8'hA6, 4);
        bus_start();
        wbyte(8'hA6, a); chk(a, "R7 restart after mid-byte start", a, 1);
        wbyte(8'h20, a);
        wbyte(8'h99, a);
        bus_stop();
        chk(mem[32] == 8'h99, "R7 write after restart", mem[32], 8'h99);
        wc = wr_count;
        bus_start();
        wbyte(8'hA6, a); wbyte(8'h21, a);
        send_bits(8'h44, 3);
        m_sda_low = 1'b1; wclk(q);
        m_scl = 1'b1; wclk(q);
        m_sda_low = 1'b0; wclk(2 * q);
        chk(sda_oe == 1'b0, "R7 released after mid-byte stop", sda_oe, 0);
        chk(wr_count == wc && mem[33] == 8'h00, "R7 no write after stop", wr_count, wc);
    endtask

    task automatic t_slow_rate();
        bit a;
        logic [7:0] d;
        q = 60;
        addr_sel = 1'b1;
        bus_start();
        wbyte(8'h3A, a); chk(a, "R9 slow ack", a, 1);
        wbyte(8'h2A, a);
        wbyte(8'h5C, a);
        bus_start();
        wbyte(8'h3B, a);
        rbyte(1'b0, d);
        bus_stop();
        chk(d == 8'h00, "R9 slow read next reg", d, 8'h00);
        chk(mem[42] == 8'h5C, "R9 slow write", mem[42], 8'h5C);
        q = 3;
        bus_start();
        wbyte(8'h3A, a); wbyte(8'h2B, a); wbyte(8'hE1, a);
        bus_stop();
        chk(mem[43] == 8'hE1, "R9 minimum phase write", mem[43], 8'hE1);
        q = 8;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'h00;
        wclk(5);
        t_reset();
        rst_n = 1'b1;
        wclk(5);
        t_reset();
        t_write_hi();
        t_read_burst();
        t_mismatch();
        t_strap_lo_wrap();
        t_stop_start_read();
        t_abort();
        t_slow_rate();
        summary();
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule